// File: doc/BRIEF.md
# Burst Address Sequencer

This block supplies the word address for a synchronous burst memory. When a burst begins it captures the external address. For the rest of the burst it keeps the upper address bits fixed and steps only the two lowest bits. It steps them once for each cycle in which the advance input is asserted. The low bits wrap inside the aligned four-word block, in linear or interleaved order.

Two strobes can start a burst: one driven by the processor and one driven by the cache controller. The processor strobe counts only while the primary chip select is active. The controller strobe always counts.

All inputs are sampled on the rising clock edge. The output address and its valid flag come from registered state and change only after an edge. Because the output is a plain address bus, a consumer cannot hold off a step by applying back-pressure. The advance input is the only flow control, and the address holds for as long as advance stays deasserted.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `addr_valid` is 0 and `addr_out` is all zeros.
- R2: When `ctrl_strobe_n` is 0 at a rising edge, `addr_out` equals the `addr_in` sampled at that edge and `addr_valid` is 1. This holds whatever the level of `chip_sel_n`.
- R3: When `proc_strobe_n` is 0 and `chip_sel_n` is 0 at a rising edge, the block loads `addr_in` in the same way as R2.
- R4: When `chip_sel_n` is 1, `proc_strobe_n` has no effect: with no other strobe and no advance, `addr_out` and `addr_valid` stay unchanged.
- R5: With `addr_valid` at 1, no strobe asserted and `advance_n` at 0, the low two address bits take their next value in the burst order. With `advance_n` at 1 and no strobe asserted, `addr_out` holds.
- R6: With `burst_order` at 0 (linear) when the burst started, step k of the burst gives low bits equal to (start + k) mod 4.
- R7: With `burst_order` at 1 (interleaved) when the burst started, step k of the burst gives low bits equal to start XOR k.
- R8: Advancing never changes `addr_out[17:2]`. After four advances the low bits return to their starting value, with no carry into bit 2.
- R9: A strobe that qualifies as a load in the same cycle as `advance_n` at 0 loads the new address, and the advance is dropped.
- R10: `burst_order` is sampled only when a burst starts. Changing it in the middle of a burst does not alter the sequence.
- R11: While `addr_valid` is 0, `advance_n` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_in | input | 18 | External word address |
| proc_strobe_n | input | 1 | Processor address strobe, active low, gated by chip select |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low |
| advance_n | input | 1 | Burst advance, active low |
| burst_order | input | 1 | 0 = linear order, 1 = interleaved order |
| chip_sel_n | input | 1 | Primary chip select, active low |
| addr_out | output | 18 | Current internal word address |
| addr_valid | output | 1 | High once a burst has been started |

## Verification
The assertions are checked on every clock cycle. They cover:
- loading from either strobe, including the case where load and advance come together;
- blocking of the processor strobe while chip select is high;
- holding of the address when the block is idle;
- the upper bits staying fixed during an advance;
- the single linear step.

Some behaviour is spread over several cycles, so only the bench scenarios can show it:
- the complete four-step sequences for every starting offset in both orders;
- the return to the start offset after the fourth advance;
- the fact that the order is held when `burst_order` changes in the middle of a burst.

// File: rtl/bas_pkg.sv
package bas_pkg;
  typedef enum logic {
    ORDER_LINEAR      = 1'b0,
    ORDER_INTERLEAVED = 1'b1
  } order_e;
endpackage

// File: rtl/bas_start_ctl.sv
module bas_start_ctl (
  input  logic proc_strobe_n,
  input  logic ctrl_strobe_n,
  input  logic chip_sel_n,
  input  logic advance_n,
  input  logic burst_live,
  output logic load,
  output logic step
);
  logic proc_ok;
  logic ctrl_ok;

  always_comb begin
    proc_ok = ~proc_strobe_n & ~chip_sel_n;
    ctrl_ok = ~ctrl_strobe_n;
    load    = proc_ok | ctrl_ok;
    step    = ~load & ~advance_n & burst_live;
  end
endmodule

// File: rtl/bas_hold_reg.sv
module bas_hold_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/bas_burst_counter.sv
module bas_burst_counter
  import bas_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [CNT_W-1:0] start_in,
  input  logic             order_in,
  output logic [CNT_W-1:0] low_o
);
  logic [CNT_W-1:0] start_q;
  logic [CNT_W-1:0] cnt_q;
  order_e           order_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      cnt_q   <= '0;
      order_q <= ORDER_LINEAR;
    end else if (load) begin
      start_q <= start_in;
      cnt_q   <= '0;
      order_q <= order_e'(order_in);
    end else if (step) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    if (order_q == ORDER_INTERLEAVED) low_o = start_q ^ cnt_q;
    else                              low_o = start_q + cnt_q;
  end

  // R6
  lin_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && order_q == ORDER_LINEAR) |=> low_o == $past(low_o) + 1'b1);
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W = 18,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              proc_strobe_n,
  input  logic              ctrl_strobe_n,
  input  logic              advance_n,
  input  logic              burst_order,
  input  logic              chip_sel_n,
  output logic [ADDR_W-1:0] addr_out,
  output logic              addr_valid
);
  localparam int HI_W = ADDR_W - CNT_W;

  logic            load;
  logic            step;
  logic [HI_W-1:0] hi_q;
  logic [CNT_W-1:0] low;

  bas_start_ctl u_ctl (
    .proc_strobe_n (proc_strobe_n),
    .ctrl_strobe_n (ctrl_strobe_n),
    .chip_sel_n    (chip_sel_n),
    .advance_n     (advance_n),
    .burst_live    (addr_valid),
    .load          (load),
    .step          (step)
  );

  bas_hold_reg #(.W(HI_W)) u_hi (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .d     (addr_in[ADDR_W-1:CNT_W]),
    .q     (hi_q)
  );

  bas_burst_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .step     (step),
    .start_in (addr_in[CNT_W-1:0]),
    .order_in (burst_order),
    .low_o    (low)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)    addr_valid <= 1'b0;
    else if (load) addr_valid <= 1'b1;
  end

  assign addr_out = {hi_q, low};

  // R2
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_strobe_n |=> (addr_out == $past(addr_in)) && addr_valid);
  // R3
  proc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_strobe_n && !chip_sel_n) |=> (addr_out == $past(addr_in)) && addr_valid);
  // R4
  proc_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_sel_n && ctrl_strobe_n && advance_n) |=> $stable(addr_out) && $stable(addr_valid));
  // R8
  hi_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_strobe_n && (proc_strobe_n || chip_sel_n) && !advance_n)
      |=> $stable(addr_out[ADDR_W-1:CNT_W]));
  // R11
  idle_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_valid && ctrl_strobe_n && (proc_strobe_n || chip_sel_n)) |=> !addr_valid && $stable(addr_out));
endmodule

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [17:0] addr_in;
  logic        proc_strobe_n, ctrl_strobe_n, advance_n, burst_order, chip_sel_n;
  logic [17:0] addr_out;
  logic        addr_valid;

  int n_run  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  burst_addr_seq u0 (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
    .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n),
    .advance_n(advance_n), .burst_order(burst_order),
    .chip_sel_n(chip_sel_n), .addr_out(addr_out), .addr_valid(addr_valid)
  );

  // {order, start offset, expected low bits for steps 0..3}
  localparam logic [10:0] VEC [8] = '{
    {1'b0, 2'd0, 8'b00_01_10_11},
    {1'b0, 2'd1, 8'b01_10_11_00},
    {1'b0, 2'd2, 8'b10_11_00_01},
    {1'b0, 2'd3, 8'b11_00_01_10},
    {1'b1, 2'd0, 8'b00_01_10_11},
    {1'b1, 2'd1, 8'b01_00_11_10},
    {1'b1, 2'd2, 8'b10_11_00_01},
    {1'b1, 2'd3, 8'b11_10_01_00}
  };

  task automatic chk(input string req, input logic [18:0] act, input logic [18:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    proc_strobe_n = 1'b1; ctrl_strobe_n = 1'b1; advance_n = 1'b1;
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; idle();
    cyc(); cyc();
    rst_n = 1'b1;
  endtask

  initial begin
    #150000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr_in = '0; burst_order = 1'b0; chip_sel_n = 1'b0; idle();
    do_reset();
    // R1 reset state
    chk("R1", {addr_valid, addr_out}, {1'b0, 18'h0});
    // R11 advance before any burst is ignored
    advance_n = 1'b0; cyc(); idle();
    chk("R11", {addr_valid, addr_out}, {1'b0, 18'h0});

    // table walk: R2, R6, R7, R8
    for (int i = 0; i < 8; i++) begin
      logic [17:0] a;
      a = {16'hA5C3 ^ 16'(i * 16'h1111), VEC[i][9:8]};
      addr_in = a; burst_order = VEC[i][10]; chip_sel_n = 1'b1;
      ctrl_strobe_n = 1'b0; cyc(); idle();
      addr_in = ~a;
      chk("R2", {addr_valid, addr_out}, {1'b1, a});
      for (int k = 1; k < 5; k++) begin
        logic [1:0] e;
        e = (k == 4) ? VEC[i][7:6] : 2'(VEC[i][7:0] >> (2 * (3 - k)));
        advance_n = 1'b0; cyc(); idle();
        chk(VEC[i][10] ? "R7 R8" : "R6 R8", {1'b1, addr_out}, {1'b1, a[17:2], e});
      end
    end

    // R3 processor strobe with chip select active
    chip_sel_n = 1'b0; addr_in = 18'h12345; burst_order = 1'b0;
    proc_strobe_n = 1'b0; cyc(); idle();
    chk("R3", {addr_valid, addr_out}, {1'b1, 18'h12345});

    // R4 processor strobe blocked by chip select
    chip_sel_n = 1'b1; addr_in = 18'h3FFFE;
    proc_strobe_n = 1'b0; cyc(); idle();
    chk("R4", {addr_valid, addr_out}, {1'b1, 18'h12345});

    // R5 hold without advance, then one step
    cyc(); cyc();
    chk("R5", {1'b0, addr_out}, {1'b0, 18'h12345});
    advance_n = 1'b0; cyc(); idle();
    chk("R5", {1'b0, addr_out}, {1'b0, 18'h12346});

    // R9 strobe together with advance loads
    addr_in = 18'h2AAA9; ctrl_strobe_n = 1'b0; advance_n = 1'b0; cyc(); idle();
    chk("R9", {1'b0, addr_out}, {1'b0, 18'h2AAA9});

    // R10 order latched at burst start: start interleaved at offset 1, switch to linear
    addr_in = 18'h00401; burst_order = 1'b1; ctrl_strobe_n = 1'b0; cyc(); idle();
    burst_order = 1'b0;
    advance_n = 1'b0; cyc();
    chk("R10", {1'b0, addr_out}, {1'b0, 18'h00400});
    cyc(); idle();
    chk("R10", {1'b0, addr_out}, {1'b0, 18'h00403});

    // R1 reset clears a live burst
    do_reset();
    chk("R1", {addr_valid, addr_out}, {1'b0, 18'h0});

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule